// File: doc/BRIEF.md
# Timer Channel Pin Controller with Edge Interrupts

This block owns the single external pin of one general-purpose timer channel. Software configures it through two 32-bit words on a plain write/read register port: a mode word that chooses what the pin does, and a status word that holds event flags and shows the live pin level. The counter and its compare and pulse-width outputs sit elsewhere. This block only decodes the pin function, drives the pad, and turns pin edges into an interrupt.

When the pin is used as a general-purpose output, software chooses low, high or released. An open-drain option turns a high level into a released pin, so an external pull-up can set the level. In capture mode the pin is only an input. Its level is synchronized and watched for the selected edge polarity. A qualifying edge sets a sticky flag. If a second edge arrives while that flag is still set, an overrun flag is also raised. Software clears flags by writing ones to them. The interrupt line reports any pending flag while the enable bit is set.

Top module: `tmr_pin_unit`

## Requirements
- R1: After reset the mode word and the status word both read zero, `pin_oe` is 0 and `irq` is 0.
- R2: A write to the mode word (address 0) stores only bits [2:0], [5:4], 8, 9 and [17:16]. Every other bit reads back as zero, so a write of 32'hFFFFFFFF reads back as 32'h00030337.
- R3: When mode[2:0] = 4 (GPIO), mode[5:4] = 2'b10 drives the pin low (`pin_oe`=1, `pin_out`=0), 2'b11 drives it high (`pin_oe`=1, `pin_out`=1), and 2'b00 leaves it as an input (`pin_oe`=0).
- R4: With mode bit 9 set in GPIO mode, a high request releases the pin (`pin_oe`=0) while a low request still drives 0. The pin is never driven high while bit 9 is set.
- R5: Every mode[2:0] value other than 4 (0 unused, 1 capture, 2, 3, 5 to 7) keeps `pin_oe` at 0 and `pin_out` at 0, whatever mode[5:4] holds.
- R6: Status bit 8 (address 1) shows `pin_in` delayed by two clock edges through the synchronizer.
- R7: When mode[2:0] = 1, mode[17:16] selects the edge: 01 rising, 10 falling, 11 either, 00 none. A qualifying edge of the synchronized level sets status bit 0 on the third rising clock edge after `pin_in` changes.
- R8: In capture mode the GPIO drive bits have no effect on the pin. `pin_oe` stays 0 even with mode[5:4] = 2'b11.
- R9: When mode[2:0] is not 1, pin edges set no status flag.
- R10: A qualifying edge that arrives while status bit 0 is already set also sets status bit 1 (overrun).
- R11: A write to the status word clears each of bits [3:0] written as 1 and leaves bits written as 0 unchanged. A status write cannot change bit 8.
- R12: `irq` is 1 exactly when mode bit 8 is set and any of status bits [3:0] is set. Clearing bit 8 masks `irq` but keeps the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 2 | Word select: 0 mode, 1 status, others read zero |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | 1 | Level seen at the pad, asynchronous |
| pin_out | output | 1 | Level to drive when `pin_oe` is 1 |
| pin_oe | output | 1 | Pad output enable |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench checks that the open-drain option really releases a high request and still sinks a low one. A design that drove high would fight the external pull-up. It also confirms that capture mode ignores leftover drive bits, since a stale output setting would otherwise drive into the signal being captured. Each edge polarity is tried against both pin transitions, so swapped rise and fall decoding, or an edge selector that fires on none, shows up as a wrong flag. Finally it covers masking with flags retained, partial write-one-to-clear, and the overrun flag. Each targets a typical slip: flags lost when the enable drops, clears applied to bits written as zero, or a second edge that goes unrecorded.

// File: rtl/tmr_pin_pkg.sv
// Shared field positions, pin function codes and the decoded mode record
// for the timer pin controller. Assumes a 32-bit register word.
package tmr_pin_pkg;

    localparam int WORD_W = 32;
    localparam int FLAG_W = 4;

    // Bit positions within the mode word
    localparam int SEL_LSB   = 0;
    localparam int DRV_LSB   = 4;
    localparam int IEN_BIT   = 8;
    localparam int ODRN_BIT  = 9;
    localparam int EDGE_LSB  = 16;

    // Bit positions within the status word
    localparam int FLAG_EVENT   = 0;
    localparam int FLAG_OVERRUN = 1;
    localparam int LEVEL_BIT    = 8;

    // Writable bits of the mode word
    localparam logic [WORD_W-1:0] MODE_KEEP = 32'h0003_0337;

    typedef enum logic [2:0] {
        PIN_OFF     = 3'd0,
        PIN_CAPTURE = 3'd1,
        PIN_COMPARE = 3'd2,
        PIN_PULSE   = 3'd3,
        PIN_GPIO    = 3'd4
    } pin_fn_e;

    typedef struct packed {
        pin_fn_e    fn;
        logic [1:0] drive;
        logic       irq_en;
        logic       open_drain;
        logic [1:0] edge_sel;
    } mode_fields_t;

    function automatic mode_fields_t unpack_mode(input logic [WORD_W-1:0] m);
        mode_fields_t f;
        f.fn         = pin_fn_e'(m[SEL_LSB +: 3]);
        f.drive      = m[DRV_LSB +: 2];
        f.irq_en     = m[IEN_BIT];
        f.open_drain = m[ODRN_BIT];
        f.edge_sel   = m[EDGE_LSB +: 2];
        return f;
    endfunction

endpackage

// File: rtl/tmr_pin_sync.sv
// Multi-stage synchronizer for the asynchronous pad input.
// Assumes STAGES >= 2; the output is the input delayed by STAGES edges.
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the pad level through the flop chain
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/tmr_pin_edge.sv
// Edge detector and sticky flag store for capture mode.
// Compares the synchronized level with its value one cycle earlier; a
// qualifying edge sets the event flag, and the overrun flag when the event
// flag survives the same cycle's clear. A set wins over a clear.
module tmr_pin_edge
    import tmr_pin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level,
    input  logic              arm,
    input  logic [1:0]        edge_sel,
    input  logic [FLAG_W-1:0] clr_mask,
    output logic [FLAG_W-1:0] flags
);

    logic              level_d;
    logic              rise, fall, hit;
    logic [FLAG_W-1:0] kept;
    logic [FLAG_W-1:0] flags_nx;

    // Remember last cycle's synchronized level
    always_ff @(posedge clk) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign rise = level & ~level_d;
    assign fall = ~level & level_d;
    assign hit  = arm & ((edge_sel[0] & rise) | (edge_sel[1] & fall));

    // Apply clears first, then set flags on a qualifying edge
    always_comb begin
        kept     = flags & ~clr_mask;
        flags_nx = kept;
        if (hit) begin
            flags_nx[FLAG_EVENT] = 1'b1;
            if (kept[FLAG_EVENT]) flags_nx[FLAG_OVERRUN] = 1'b1;
        end
    end

    // Hold the sticky flags
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_nx;
    end

endmodule

// File: rtl/tmr_pin_pad.sv
// Pad drive decode. Only the GPIO function may enable the output; open
// drain turns a high request into a released pin. Purely combinational.
module tmr_pin_pad
    import tmr_pin_pkg::*;
(
    input  mode_fields_t cfg,
    output logic         oe,
    output logic         out
);

    // Derive output enable and drive level from the mode fields
    always_comb begin
        oe  = 1'b0;
        out = 1'b0;
        if (cfg.fn == PIN_GPIO && cfg.drive[1]) begin
            if (cfg.drive[0]) begin
                oe  = ~cfg.open_drain;
                out = ~cfg.open_drain;
            end else begin
                oe  = 1'b1;
                out = 1'b0;
            end
        end
    end

endmodule

// File: rtl/tmr_pin_unit.sv
// Timer channel pin controller: mode and status words on a simple
// write/read port, pad drive decode, synchronized edge capture and a level
// interrupt. Assumes a single clock and a pad input that may be asynchronous.
module tmr_pin_unit
    import tmr_pin_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic              irq
);

    localparam logic [ADDR_W-1:0] OFS_MODE = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(1);

    logic [WORD_W-1:0] mode_q;
    logic [FLAG_W-1:0] flags_q;
    logic [FLAG_W-1:0] clr_mask;
    logic              level;
    mode_fields_t      cfg;

    assign cfg = unpack_mode(mode_q);

    // Mode word storage, keeping only defined fields
    always_ff @(posedge clk) begin
        if (!rst_n)                             mode_q <= '0;
        else if (bus_we && bus_addr == OFS_MODE) mode_q <= bus_wdata & MODE_KEEP;
    end

    assign clr_mask = (bus_we && bus_addr == OFS_STAT) ? bus_wdata[FLAG_W-1:0] : '0;

    tmr_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pin_in),
        .q     (level)
    );

    tmr_pin_edge u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .level    (level),
        .arm      (cfg.fn == PIN_CAPTURE),
        .edge_sel (cfg.edge_sel),
        .clr_mask (clr_mask),
        .flags    (flags_q)
    );

    tmr_pin_pad u_pad (
        .cfg (cfg),
        .oe  (pin_oe),
        .out (pin_out)
    );

    // Read mux for the addressed word
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == OFS_MODE) begin
            bus_rdata = mode_q;
        end else if (bus_addr == OFS_STAT) begin
            bus_rdata[FLAG_W-1:0] = flags_q;
            bus_rdata[LEVEL_BIT]  = level;
        end
    end

    assign irq = cfg.irq_en & (|flags_q);

endmodule

// File: rtl/tmr_pin_unit_chk.sv
// Property checker for tmr_pin_unit, attached by bind. Watches ports and
// the registered mode and flag state.
module tmr_pin_unit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_we,
    input logic [1:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic        pin_in,
    input logic        pin_out,
    input logic        pin_oe,
    input logic        irq,
    input logic [31:0] mode_q,
    input logic [3:0]  flags_q,
    input logic        level
);

    logic [1:0] since_rst;

    // Count cycles after reset so that delayed checks look only at valid history
    always_ff @(posedge clk) begin
        if (!rst_n)              since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    AST_CAPTURE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[2:0] == 3'd1) |-> !pin_oe);                                   // R8

    AST_OPEN_DRAIN_NO_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q[9] && pin_oe) |-> !pin_out);                                  // R4

    AST_ONLY_GPIO_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        pin_oe |-> (mode_q[2:0] == 3'd4));                                    // R5

    AST_FLAG_SET_NEEDS_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !$past(flags_q[0]) && flags_q[0]) |-> ($past(mode_q[2:0]) == 3'd1)); // R9

    AST_FLAG_CLEAR_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (flags_q[0] && !(bus_we && bus_addr == 2'd1 && bus_wdata[0])) |=> flags_q[0]); // R11

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mode_q[8] && flags_q != 4'd0));                              // R12

    AST_LEVEL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (level == $past(pin_in, 2)));                 // R6

endmodule

bind tmr_pin_unit tmr_pin_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pin_in    (pin_in),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe),
    .irq       (irq),
    .mode_q    (mode_q),
    .flags_q   (flags_q),
    .level     (level)
);

// File: tb/tmr_pin_unit_test.sv
module tmr_pin_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        pin_in = 1'b0;
    logic        pin_out, pin_oe, irq;

    int n_checks = 0;
    int n_fail   = 0;
    logic done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    tmr_pin_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_in    (pin_in),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe),
        .irq       (irq)
    );

    typedef struct packed {
        logic [31:0] mode;
        logic        p0;
        logic        p1;
        logic        exp_oe;
        logic        exp_out;
        logic        exp_flag;
    } vec_t;

    // mode, pin before, pin after, expected oe, out, event flag
    localparam vec_t VECS [15] = '{
        '{32'h0001_0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // capture rising, rise
        '{32'h0001_0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},  // capture rising, fall
        '{32'h0002_0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // capture falling, fall
        '{32'h0002_0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // capture falling, rise
        '{32'h0003_0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // capture both, rise
        '{32'h0003_0001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},  // capture both, fall
        '{32'h0000_0001, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // capture none
        '{32'h0003_0031, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},  // capture ignores drive bits
        '{32'h0003_0024, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // gpio low, no flag
        '{32'h0003_0034, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},  // gpio high, no flag
        '{32'h0000_0234, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // gpio high open drain
        '{32'h0000_0224, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0},  // gpio low open drain
        '{32'h0003_0004, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // gpio input
        '{32'h0003_0030, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0},  // unused, drive bits set
        '{32'h0003_0033, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}   // function 3, drive bits set
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end

    initial begin : main
        logic [31:0] r;
        settle(3);
        rst_n = 1'b1;
        settle(1);

        // R1 reset state
        rd(2'd0, r); check("R1 mode after reset", r, 32'h0);
        rd(2'd1, r); check("R1 status after reset", r, 32'h0);
        check("R1 oe after reset", {31'd0, pin_oe}, 32'd0);
        check("R1 irq after reset", {31'd0, irq}, 32'd0);

        // R2 mode readback mask
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, r); check("R2 mode mask", r, 32'h0003_0337);
        wr(2'd0, 32'h0);

        // Vector table: R3 R4 R5 R7 R8 R9
        foreach (VECS[i]) begin
            pin_in = VECS[i].p0;
            wr(2'd0, VECS[i].mode);
            settle(4);
            wr(2'd1, 32'h0000_000F);
            pin_in = VECS[i].p1;
            settle(4);
            check($sformatf("R3/R4/R5/R8 oe vec %0d", i), {31'd0, pin_oe}, {31'd0, VECS[i].exp_oe});
            check($sformatf("R3/R4/R5 out vec %0d", i), {31'd0, pin_out}, {31'd0, VECS[i].exp_out});
            rd(2'd1, r);
            check($sformatf("R7/R9 status vec %0d", i), r,
                  {23'd0, VECS[i].p1, 7'd0, VECS[i].exp_flag});
        end

        // R6 level latency through the synchronizer
        wr(2'd0, 32'h0);
        pin_in = 1'b0;
        settle(4);
        pin_in = 1'b1;
        @(negedge clk);
        rd(2'd1, r); check("R6 level after one edge", {31'd0, r[8]}, 32'd0);
        @(negedge clk);
        rd(2'd1, r); check("R6 level after two edges", {31'd0, r[8]}, 32'd1);

        // R7 exact latency: flag appears on third edge after the change
        wr(2'd0, 32'h0001_0101);
        pin_in = 1'b0;
        settle(4);
        wr(2'd1, 32'h0000_000F);
        pin_in = 1'b1;
        settle(2);
        rd(2'd1, r); check("R7 flag not yet after two edges", {31'd0, r[0]}, 32'd0);
        @(negedge clk);
        rd(2'd1, r); check("R7 flag after three edges", {31'd0, r[0]}, 32'd1);

        // R12 irq follows enable and flags
        check("R12 irq with flag and enable", {31'd0, irq}, 32'd1);
        wr(2'd0, 32'h0001_0001);
        check("R12 irq masked", {31'd0, irq}, 32'd0);
        rd(2'd1, r); check("R12 flag kept while masked", r[3:0], 4'h1);
        wr(2'd0, 32'h0001_0101);
        check("R12 irq after re-enable", {31'd0, irq}, 32'd1);

        // R10 overrun on second edge with event pending
        pin_in = 1'b0; settle(4);
        pin_in = 1'b1; settle(4);
        rd(2'd1, r); check("R10 overrun flag", r[3:0], 4'h3);

        // R11 write-one-to-clear details
        wr(2'd1, 32'hFFFF_FEF0);
        rd(2'd1, r); check("R11 zero bits keep flags", r, 32'h0000_0103);
        wr(2'd1, 32'h0000_0002);
        rd(2'd1, r); check("R11 partial clear", r, 32'h0000_0101);
        check("R12 irq with one flag", {31'd0, irq}, 32'd1);
        wr(2'd1, 32'h0000_0001);
        rd(2'd1, r); check("R11 full clear", r, 32'h0000_0100);
        check("R12 irq after clear", {31'd0, irq}, 32'd0);

        done = 1'b1;
        finish_run();
    end

endmodule